// File: doc/BRIEF.md
# UART Receive Queue with Status Registers

This block is the receive side of a memory-mapped serial port. Characters arriving from a deserializer, one per strobe, are written into a first-in first-out queue. Software drains the queue through a receive-buffer register and polls a set of status registers, all reached through a register select with separate read and write strobes. A line break is treated as a received null character and is recorded in an error register.

With queue mode switched off in the control register, the block falls back to a single holding register that keeps only the most recent character. Two one-cycle flags report received characters and error conditions to an interrupt controller elsewhere. The live queue occupancy is also provided as a port.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the queue is empty (rx_count 0), the control register reads 0, the error register reads 0, the line status register reads 0x6, and both source flags are low.
- R2: In queue mode (control bit 0 set) stored characters are returned by buffer reads (select 4) oldest first, each read removes one, and rx_count follows every push and pop.
- R3: A control write (select 0) stores the value with bits 1 and 2 read back as 0; writing bit 1 empties the receive queue and clears data ready, and bit 2 has no effect on the receive queue.
- R4: Every received character or break raises src_rx for exactly one cycle on the following cycle, including a character that is dropped; src_rx is low in every other cycle.
- R5: A buffer read in queue mode with the queue empty returns 0, removes nothing and raises src_err for one cycle.
- R6: A character arriving while the queue holds DEPTH entries is dropped, leaves the contents unchanged, raises src_err for one cycle and sets error bit 0 (overrun).
- R7: The queue status register (select 1) holds the occupancy in bits [7:0] and a full flag in bit 8; while full, bits [7:0] read 0; bits [23:16] and bit 24 (transmit occupancy and full) read 0.
- R8: A break pulse stores 0x00 (into the queue in queue mode, into the holding register otherwise) and sets error bit 3.
- R9: A read of the error register (select 3) returns bits 0 overrun, 1 parity, 2 framing, 3 break, and clears them; a bit set by an event in the same cycle as the read survives.
- R10: The line status register (select 2) reads bit 0 as data ready and bits 2 and 1 as 1; in queue mode data ready is 1 exactly while the queue is non-empty.
- R11: With queue mode off, each character overwrites the holding register and sets data ready; a buffer read returns the held character and clears data ready unless a character arrives in the same cycle.
- R12: Read data appears on reg_rdata one cycle after the read strobe; selects 5 to 7 read 0, and writes to any select other than 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received character strobe |
| rx_byte | input | 8 | Received character |
| brk_det | input | 1 | Break detected pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| src_rx | output | 1 | Receive source flag pulse |
| src_err | output | 1 | Error source flag pulse |
| rx_count | output | 5 | Current queue occupancy |

## Verification
Every result of this block is due exactly one clock after its stimulus: read data, both source flags, the new occupancy and the effect of a control write all come from registers loaded on the edge that samples the strobes. The bench drives strobes at the falling edge, advances one rising edge, and compares all outputs at the next falling edge against a model updated in the same step, so no result is sampled early or late. Directed steps cover full, overflow, empty reads, break, error clearing and holding-register mode; a seeded random phase mixes all strobes.

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 3,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          brk_det,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          src_rx,
  output logic          src_err,
  output logic [CW-1:0] rx_count
);
  localparam logic [AW-1:0] SEL_CTL = AW'(0);
  localparam logic [AW-1:0] SEL_QST = AW'(1);
  localparam logic [AW-1:0] SEL_LST = AW'(2);
  localparam logic [AW-1:0] SEL_ERR = AW'(3);
  localparam logic [AW-1:0] SEL_BUF = AW'(4);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_n;
  logic [31:0]   ctrl_q;
  logic          rdy_q, rdy_n;
  logic [3:0]    err_q;
  logic [DW-1:0] hold_q;
  logic [31:0]   rd_mux;

  wire          fifo_en = ctrl_q[0];
  wire          ev      = rx_valid | brk_det;
  wire [DW-1:0] din     = brk_det ? '0 : rx_byte;
  wire          clr_rx  = reg_wr && reg_addr == SEL_CTL && reg_wdata[1];
  wire          rd_buf  = reg_rd && reg_addr == SEL_BUF;
  wire          rd_err  = reg_rd && reg_addr == SEL_ERR;
  wire          full    = cnt == CW'(DEPTH);
  wire          empty   = cnt == '0;
  wire          pop     = fifo_en && rd_buf && !empty && !clr_rx;
  wire          push    = fifo_en && ev && !full && !clr_rx;
  wire          drop    = fifo_en && ev && full && !clr_rx;
  wire          rd_none = fifo_en && rd_buf && empty;
  wire [7:0]    cnt_fld = full ? 8'h00 : 8'(cnt);

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (clr_rx) cnt_n = '0;
    else        cnt_n = cnt + CW'(push) - CW'(pop);
  end

  always_comb begin
    if (fifo_en)     rdy_n = cnt_n != '0;
    else if (ev)     rdy_n = 1'b1;
    else if (rd_buf) rdy_n = 1'b0;
    else             rdy_n = rdy_q;
  end

  always_comb begin
    unique case (reg_addr)
      SEL_CTL: rd_mux = ctrl_q;
      SEL_QST: rd_mux = {7'd0, 1'b0, 8'd0, 7'd0, full, cnt_fld};
      SEL_LST: rd_mux = {29'd0, 2'b11, rdy_q};
      SEL_ERR: rd_mux = {28'd0, err_q};
      SEL_BUF: rd_mux = fifo_en ? (empty ? 32'd0 : 32'(mem[rp])) : 32'(hold_q);
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      ctrl_q <= '0; rdy_q <= 1'b0; err_q <= '0; hold_q <= '0;
      reg_rdata <= '0; src_rx <= 1'b0; src_err <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      rdy_q <= rdy_n;
      if (clr_rx) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push) wp <= inc(wp);
        if (pop)  rp <= inc(rp);
      end
      if (reg_wr && reg_addr == SEL_CTL) ctrl_q <= reg_wdata & ~32'h6;
      if (!fifo_en && ev) hold_q <= din;
      err_q   <= (rd_err ? 4'd0 : err_q) | {brk_det, 2'b00, drop};
      if (reg_rd) reg_rdata <= rd_mux;
      src_rx  <= ev;
      src_err <= drop | rd_none;
    end
  end

  assign rx_count = cnt;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          brk_det,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          src_rx,
  input logic          src_err,
  input logic [CW-1:0] rx_count,
  input logic          fifo_en,
  input logic [3:0]    err_q
);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  a_r3_rx_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(0) && reg_wdata[1]) |=> rx_count == '0);

  a_r4_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || brk_det) |=> src_rx);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid || brk_det) |=> !src_rx);

  a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && reg_rd && reg_addr == AW'(4) && rx_count == '0 && !reg_wr)
      |=> (src_err && reg_rdata == 32'd0));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_valid && rx_count == CW'(DEPTH) && !reg_rd && !reg_wr)
      |=> (src_err && rx_count == CW'(DEPTH) && err_q[0]));

  a_r8_break_flag: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |=> err_q[3]);

  a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == AW'(3) && !rx_valid && !brk_det) |=> err_q == 4'd0);
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .brk_det(brk_det),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .src_rx(src_rx), .src_err(src_err), .rx_count(rx_count),
  .fifo_en(ctrl_q[0]), .err_q(err_q)
);

// File: tb/uart_rx_queue_tb.sv
module uart_rx_queue_tb;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, brk_det = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        src_rx, src_err;
  logic [4:0]  rx_count;

  int n_vec = 0, n_bad = 0;
  logic [7:0]  m_mem [D];
  int          m_wp = 0, m_rp = 0, m_cnt = 0;
  logic [31:0] m_ctrl = '0;
  logic        m_rdy = 1'b0;
  logic [3:0]  m_err = '0;
  logic [7:0]  m_hold = '0;

  always #2 clk = ~clk;

  uart_rx_queue u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .brk_det(brk_det), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_rx(src_rx),
    .src_err(src_err), .rx_count(rx_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic string rd_tag(input logic [2:0] a, input logic fen);
    case (a)
      3'd0: return "R3";
      3'd1: return "R7";
      3'd2: return "R10";
      3'd3: return "R9";
      3'd4: return fen ? "R2" : "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic cyc(input logic v, input logic [7:0] b, input logic bk,
                     input logic w, input logic r, input logic [2:0] a,
                     input logic [31:0] wd);
    logic [31:0] e_rd;
    logic        e_err, fen, clr, rdb, drop, full;
    logic [7:0]  din;
    int          oc;
    rx_valid = v; rx_byte = b; brk_det = bk;
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = wd;
    fen = m_ctrl[0]; din = bk ? 8'h00 : b;
    clr = w && a == 3'd0 && wd[1];
    rdb = r && a == 3'd4;
    full = m_cnt == D;
    oc = m_cnt; drop = 1'b0; e_err = 1'b0;
    case (a)
      3'd0: e_rd = m_ctrl;
      3'd1: e_rd = {23'd0, full, full ? 8'd0 : 8'(m_cnt)};
      3'd2: e_rd = 32'h6 | 32'(m_rdy);
      3'd3: e_rd = 32'(m_err);
      3'd4: e_rd = fen ? ((m_cnt > 0) ? 32'(m_mem[m_rp]) : 32'd0) : 32'(m_hold);
      default: e_rd = 32'd0;
    endcase
    if (clr) begin
      m_cnt = 0; m_wp = 0; m_rp = 0;
    end
    if (fen) begin
      if (rdb && oc == 0) e_err = 1'b1;
      if (!clr) begin
        if (rdb && oc > 0) begin m_rp = (m_rp + 1) % D; m_cnt--; end
        if (v || bk) begin
          if (oc < D) begin m_mem[m_wp] = din; m_wp = (m_wp + 1) % D; m_cnt++; end
          else drop = 1'b1;
        end
      end
      m_rdy = m_cnt != 0;
    end else begin
      if (rdb) m_rdy = 1'b0;
      if (v || bk) begin m_hold = din; m_rdy = 1'b1; end
    end
    e_err |= drop;
    m_err = ((r && a == 3'd3) ? 4'd0 : m_err) | {bk, 2'b00, drop};
    if (w && a == 3'd0) m_ctrl = wd & ~32'h6;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; brk_det = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    chk("R4", 32'(src_rx), 32'(v || bk));
    chk("R5|R6", 32'(src_err), 32'(e_err));
    chk("R2", 32'(rx_count), 32'(m_cnt));
    if (r) chk(rd_tag(a, fen), reg_rdata, e_rd);
  endtask

  task automatic rd(input logic [2:0] a);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, a, 32'd0);
  endtask

  task automatic rx(input logic [7:0] b);
    cyc(1'b1, b, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, a, d);
  endtask

  initial begin
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", 32'(rx_count), 0);
    chk("R1", 32'(src_rx | src_err), 0);
    rd(3'd2); chk("R1", reg_rdata, 32'h6);
    rd(3'd3); chk("R1", reg_rdata, 32'h0);
    rd(3'd0); chk("R1", reg_rdata, 32'h0);
    // R3: bits 1 and 2 self-clear, enable sticks
    wr(3'd0, 32'h7); rd(3'd0); chk("R3", reg_rdata, 32'h1);
    // R5: empty read
    rd(3'd4); chk("R5", reg_rdata, 32'h0); chk("R5", 32'(src_err), 1);
    // R7: fill to full, count field reads zero
    for (int i = 0; i < D; i++) rx(8'h30 + 8'(i));
    rd(3'd1); chk("R7", reg_rdata, 32'h100);
    rd(3'd2); chk("R10", reg_rdata, 32'h7);
    // R6: overflow
    rx(8'hAA); chk("R6", 32'(src_err), 1); chk("R6", 32'(rx_count), D);
    rd(3'd3); chk("R6", reg_rdata, 32'h1);
    rd(3'd4); chk("R2", reg_rdata, 32'h30);
    // R8: break pushes a null byte and sets bit 3
    cyc(1'b0, 8'h77, 1'b1, 1'b0, 1'b0, 3'd0, 32'd0);
    rd(3'd3); chk("R8", reg_rdata, 32'h8);
    rd(3'd3); chk("R9", reg_rdata, 32'h0);
    for (int i = 0; i < D; i++) rd(3'd4);
    chk("R8", reg_rdata, 32'h0);
    rd(3'd2); chk("R10", reg_rdata, 32'h6);
    // R3: queue reset
    rx(8'h11); rx(8'h12);
    wr(3'd0, 32'h3); chk("R3", 32'(rx_count), 0);
    rd(3'd2); chk("R3", reg_rdata, 32'h6);
    // R12: writes to other selects ignored
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hF);
    rd(3'd2); chk("R12", reg_rdata, 32'h6);
    rd(3'd3); chk("R12", reg_rdata, 32'h0);
    rd(3'd6); chk("R12", reg_rdata, 32'h0);
    // R11: holding register mode
    wr(3'd0, 32'h0);
    rx(8'h55); rx(8'h66);
    rd(3'd4); chk("R11", reg_rdata, 32'h66);
    rd(3'd2); chk("R11", reg_rdata, 32'h6);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 32'd0);
    rd(3'd4); chk("R8", reg_rdata, 32'h0);
    // random phase
    for (int k = 0; k < 6000; k++) begin
      logic v, bk, w, r;
      logic [2:0] a;
      logic [31:0] wd;
      v  = ($urandom % 10) < 4;
      bk = ($urandom % 40) == 0;
      w  = ($urandom % 30) == 0;
      r  = !w && (($urandom % 10) < 4);
      a  = w ? ((($urandom % 4) == 0) ? 3'($urandom) : 3'd0)
             : ((($urandom % 3) != 0) ? 3'd4 : 3'($urandom));
      wd = $urandom;
      wd[0] = ($urandom % 8) != 0;
      wd[1] = ($urandom % 6) == 0;
      cyc(v, 8'($urandom), bk, w, r, a, wd);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule